// File: doc/BRIEF.md
# Keyed Write Guard for Protected Configuration Registers

This block sits beside a simple register bus, with address, write data, write strobe and read strobe, and decides whether a write that targets one of three protected configuration registers may take effect. It does not hold those registers. It produces a qualifier, `wrAllow`, that the register file combines with its own write enable. When a protected write is refused, it raises a one-cycle `wrDenied` pulse and sets a sticky error flag that software can read and clear.

While the `lockCfg` input is high, a protected write is honoured only on the bus access that comes straight after a two-word key: the first key word and then the second, each written to the key register on consecutive bus accesses. That unlock covers exactly one access. Any access at all, whether a read or a write to any address, consumes or cancels it. While `lockCfg` is low, protected writes pass freely.

Top module: `keyed_write_guard`

## Requirements
- R1: After reset the guard is locked (`armed` low), `errFlag` is 0, and a protected write is refused.
- R2: While `lockCfg` is 0, a write to any of the three protected addresses (0x00, 0x04, 0x06) gets `wrAllow` high in its own cycle, and `wrDenied` stays low.
- R3: Writing 0xABCD and then 0x4321 to the key address 0x10 on two consecutive bus accesses sets `armed` high on the cycle after the second word. Cycles with neither strobe active are not accesses and do not break the sequence.
- R4: While armed, a protected write gets `wrAllow` high in the same cycle it is presented.
- R5: While armed, any other access (a read of any address, or a write to an unprotected address) cancels the unlock. `armed` falls and a following protected write is refused.
- R6: A key-register write of any value other than the expected next key word returns the guard to the locked state.
- R7: Writing 0xABCD while the first word has already been seen restarts the sequence, so the order 0xABCD, 0xABCD, 0x4321 still unlocks.
- R8: A protected write refused while `lockCfg` is 1 has `wrAllow` low and `wrDenied` high in its cycle, and `errFlag` is 1 from the next cycle on.
- R9: `errFlag` stays set until a write to the status address 0x12 with bit 0 equal to 1. A write there with bit 0 equal to 0 leaves it set.
- R10: A read of the key address returns zero. A read of the status address returns `errFlag` in bit 0 and zeros above. `rdData` is zero when no read is presented.
- R11: Each unlock admits exactly one protected write. Writing all three protected registers takes three complete key sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lockCfg | input | 1 | 1 = protection on, 0 = protected writes pass freely |
| busAddr | input | ADDR_W (8) | Register address of the current access |
| busWdata | input | DATA_W (16) | Write data |
| busWe | input | 1 | Write strobe; one cycle per access |
| busRe | input | 1 | Read strobe; one cycle per access |
| wrAllow | output | 1 | Protected write may take effect this cycle |
| wrDenied | output | 1 | Protected write refused this cycle |
| errFlag | output | 1 | Sticky refused-write flag |
| armed | output | 1 | One protected write is currently permitted by key |
| rdData | output | DATA_W (16) | Read data for key and status addresses |

## Verification
Two things happen on the same access that follows a completed key. The protected write is granted in that cycle, and the unlock is used up at the clock edge that ends it. The bench provokes this by presenting a protected write immediately after the second key word, and then a second protected write right behind it. It judges the first by a high `wrAllow` in that cycle and the second by `wrDenied` followed by `errFlag`. A behavioural model of the lock state and error flag is compared with every output on every clock. This also covers the cases where an intervening read or a restarting first key word lands where the consuming write was expected.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_KEY1   = 2'd1,
    ST_OPEN   = 2'd2
  } lockState_t;

  // What the datapath saw on the bus this cycle
  typedef struct packed {
    logic access;
    logic keyFirst;
    logic keySecond;
    logic protWr;
  } busDecode_t;

  // Control decision for this cycle
  typedef struct packed {
    logic grant;
    logic deny;
  } guardStrobe_t;

endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         lockCfg,
  input  busDecode_t   dec,
  output guardStrobe_t strobe,
  output logic         armed
);

  lockState_t state, stateNext;

  always_comb begin
    stateNext = state;
    if (dec.access) begin
      if (dec.keyFirst)
        stateNext = ST_KEY1;
      else if (dec.keySecond && state == ST_KEY1)
        stateNext = ST_OPEN;
      else
        stateNext = ST_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LOCKED;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.grant = dec.protWr && (!lockCfg || state == ST_OPEN);
    strobe.deny  = dec.protWr && !strobe.grant;
  end

  assign armed = (state == ST_OPEN);

endmodule

// File: rtl/guard_dp.sv
module guard_dp
  import guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int NUM_PROT = 3,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h12,
  parameter logic [ADDR_W*NUM_PROT-1:0] PROT_ADDRS = {8'h06, 8'h04, 8'h00},
  parameter logic [DATA_W-1:0] KEY_FIRST  = 16'hABCD,
  parameter logic [DATA_W-1:0] KEY_SECOND = 16'h4321
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              busRe,
  input  guardStrobe_t      strobe,
  output busDecode_t        dec,
  output logic              wrAllow,
  output logic              wrDenied,
  output logic              errFlag,
  output logic [DATA_W-1:0] rdData
);

  logic [NUM_PROT-1:0] protHit;

  for (genvar i = 0; i < NUM_PROT; i++) begin : gProt
    assign protHit[i] = (busAddr == PROT_ADDRS[i*ADDR_W +: ADDR_W]);
  end

  logic keyWr, statWr, errClr;

  always_comb begin
    keyWr         = busWe && (busAddr == KEY_ADDR);
    statWr        = busWe && (busAddr == STAT_ADDR);
    errClr        = statWr && busWdata[0];
    dec.access    = busWe || busRe;
    dec.keyFirst  = keyWr && (busWdata == KEY_FIRST);
    dec.keySecond = keyWr && (busWdata == KEY_SECOND);
    dec.protWr    = busWe && (|protHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             errFlag <= 1'b0;
    else if (strobe.deny)  errFlag <= 1'b1;
    else if (errClr)       errFlag <= 1'b0;
  end

  always_comb begin
    rdData = '0;
    if (busRe && !busWe && busAddr == STAT_ADDR)
      rdData[0] = errFlag;
  end

  assign wrAllow  = strobe.grant;
  assign wrDenied = strobe.deny;

endmodule

// File: rtl/keyed_write_guard.sv
module keyed_write_guard
  import guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h12,
  parameter logic [ADDR_W-1:0] PROT_ADDR0 = 8'h00,
  parameter logic [ADDR_W-1:0] PROT_ADDR1 = 8'h04,
  parameter logic [ADDR_W-1:0] PROT_ADDR2 = 8'h06,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 16'hABCD,
  parameter logic [DATA_W-1:0] KEY_SECOND = 16'h4321
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockCfg,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic              wrAllow,
  output logic              wrDenied,
  output logic              errFlag,
  output logic              armed,
  output logic [DATA_W-1:0] rdData
);

  localparam int NUM_PROT = 3;
  localparam logic [ADDR_W*NUM_PROT-1:0] PROT_ADDRS = {PROT_ADDR2, PROT_ADDR1, PROT_ADDR0};

  busDecode_t   dec;
  guardStrobe_t strobe;

  guard_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT),
    .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR), .PROT_ADDRS(PROT_ADDRS),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
    .strobe(strobe), .dec(dec),
    .wrAllow(wrAllow), .wrDenied(wrDenied), .errFlag(errFlag), .rdData(rdData)
  );

  guard_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .lockCfg(lockCfg),
    .dec(dec), .strobe(strobe), .armed(armed)
  );

endmodule

// File: rtl/guard_checker.sv
module guard_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h12,
  parameter logic [ADDR_W-1:0] PROT_ADDR0 = 8'h00,
  parameter logic [ADDR_W-1:0] PROT_ADDR1 = 8'h04,
  parameter logic [ADDR_W-1:0] PROT_ADDR2 = 8'h06,
  parameter logic [DATA_W-1:0] KEY_SECOND = 16'h4321
) (
  input logic              clk,
  input logic              rstN,
  input logic              lockCfg,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              busWe,
  input logic              busRe,
  input logic              wrAllow,
  input logic              wrDenied,
  input logic              errFlag,
  input logic              armed,
  input logic [DATA_W-1:0] rdData
);

  logic protAddr;
  assign protAddr = (busAddr == PROT_ADDR0) || (busAddr == PROT_ADDR1) || (busAddr == PROT_ADDR2);

  assert_grant_needs_key_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lockCfg && busWe && wrAllow) |-> armed);

  assert_single_use_R11: assert property (@(posedge clk) disable iff (!rstN)
    (armed && (busWe || busRe)) |=> !armed);

  assert_arm_after_key_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(busWe && busAddr == KEY_ADDR && busWdata == KEY_SECOND));

  assert_deny_sets_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrDenied |=> errFlag);

  assert_free_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!lockCfg && busWe && protAddr) |-> (wrAllow && !wrDenied));

  assert_key_reads_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !busWe && busAddr == KEY_ADDR) |-> (rdData == '0));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(busWe && busAddr == STAT_ADDR && busWdata[0])) |=> errFlag);

endmodule

bind keyed_write_guard guard_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR), .STAT_ADDR(STAT_ADDR),
  .PROT_ADDR0(PROT_ADDR0), .PROT_ADDR1(PROT_ADDR1), .PROT_ADDR2(PROT_ADDR2),
  .KEY_SECOND(KEY_SECOND)
) uChk (
  .clk(clk), .rstN(rstN), .lockCfg(lockCfg),
  .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
  .wrAllow(wrAllow), .wrDenied(wrDenied), .errFlag(errFlag),
  .armed(armed), .rdData(rdData)
);

// File: tb/tb_keyed_write_guard.sv
`timescale 1ns/1ps
module tb_keyed_write_guard;

  localparam logic [7:0]  A_KEY = 8'h10, A_STAT = 8'h12, A_P0 = 8'h00,
                          A_P1 = 8'h04, A_P2 = 8'h06, A_OTHER = 8'h20;
  localparam logic [15:0] K1 = 16'hABCD, K2 = 16'h4321;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lockCfg = 1'b1;
  logic [7:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic        wrAllow, wrDenied, errFlag, armed;
  logic [15:0] rdData;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  keyed_write_guard dut (
    .clk(clk), .rstN(rstN), .lockCfg(lockCfg),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
    .wrAllow(wrAllow), .wrDenied(wrDenied), .errFlag(errFlag),
    .armed(armed), .rdData(rdData)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 locked, 1 first word seen, 2 open
  int  mState = 0;
  bit  mErr = 0;

  function automatic bit isProt(input logic [7:0] a);
    return (a == A_P0) || (a == A_P1) || (a == A_P2);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mErr = 0;
    end else begin
      bit pw, allow;
      pw = busWe && isProt(busAddr);
      allow = pw && (!lockCfg || mState == 2);
      if (pw && !allow) mErr = 1;
      else if (busWe && busAddr == A_STAT && busWdata[0]) mErr = 0;
      if (busWe || busRe) begin
        if (busWe && busAddr == A_KEY && busWdata == K1) mState = 1;
        else if (busWe && busAddr == A_KEY && busWdata == K2 && mState == 1) mState = 2;
        else mState = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      bit pw, allow;
      logic [15:0] rd;
      pw = busWe && isProt(busAddr);
      allow = pw && (!lockCfg || mState == 2);
      rd = '0;
      if (busRe && !busWe && busAddr == A_STAT) rd[0] = mErr;
      check(wrAllow,  allow,        "R4 model wrAllow");
      check(wrDenied, pw && !allow, "R8 model wrDenied");
      check(errFlag,  mErr,         "R9 model errFlag");
      check(armed,    mState == 2,  "R3 model armed");
      check(rdData,   rd,           "R10 model rdData");
    end
  end

  task automatic acc(input bit we, input bit re, input logic [7:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    busWe = we; busRe = re; busAddr = a; busWdata = d;
    #1;
  endtask

  task automatic idle();
    @(posedge clk); #2;
    busWe = 0; busRe = 0;
    #1;
  endtask

  task automatic unlock();
    acc(1, 0, A_KEY, K1);
    acc(1, 0, A_KEY, K2);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    // R1 reset state
    check(armed, 0, "R1 armed after reset");
    check(errFlag, 0, "R1 errFlag after reset");
    acc(1, 0, A_P0, 16'h1111);
    check(wrAllow, 0, "R1 protected write refused after reset");
    // R8 refused write sets sticky flag
    check(wrDenied, 1, "R8 wrDenied pulse");
    idle();
    check(errFlag, 1, "R8 errFlag set");
    // R9 clear behaviour
    acc(1, 0, A_STAT, 16'h0000); idle();
    check(errFlag, 1, "R9 bit0=0 keeps flag");
    acc(0, 1, A_STAT, 16'h0); check(rdData, 1, "R10 status reads flag");
    acc(1, 0, A_STAT, 16'h0001); idle();
    check(errFlag, 0, "R9 bit0=1 clears flag");
    // R3 / R4 unlock and consume; R11 second write refused
    unlock(); idle(); idle();
    check(armed, 1, "R3 armed after key with idle gaps");
    acc(1, 0, A_P0, 16'h2222);
    check(wrAllow, 1, "R4 granted write");
    acc(1, 0, A_P1, 16'h3333);
    check(wrAllow, 0, "R11 second write refused");
    check(wrDenied, 1, "R11 second write denied");
    acc(1, 0, A_STAT, 16'h1); idle();
    // R5 intervening read cancels
    unlock(); acc(0, 1, A_OTHER, 16'h0);
    idle(); check(armed, 0, "R5 read cancels unlock");
    acc(1, 0, A_P2, 16'h4444); check(wrAllow, 0, "R5 write after cancel refused");
    acc(1, 0, A_STAT, 16'h1);
    // R5 unprotected write cancels
    unlock(); acc(1, 0, A_OTHER, 16'h5);
    acc(1, 0, A_P0, 16'h5555); check(wrAllow, 0, "R5 unprotected write cancels");
    acc(1, 0, A_STAT, 16'h1);
    // R6 wrong key word
    acc(1, 0, A_KEY, K1); acc(1, 0, A_KEY, 16'h1234); acc(1, 0, A_KEY, K2);
    idle(); check(armed, 0, "R6 wrong word relocks");
    acc(1, 0, A_KEY, K2); idle(); check(armed, 0, "R6 second word alone stays locked");
    // R7 first word repeated
    acc(1, 0, A_KEY, K1); acc(1, 0, A_KEY, K1); acc(1, 0, A_KEY, K2);
    idle(); check(armed, 1, "R7 repeated first word still unlocks");
    acc(0, 1, A_KEY, 16'h0); check(rdData, 0, "R10 key reads zero");
    // R11 three registers need three sequences
    unlock(); acc(1, 0, A_P0, 16'hA); check(wrAllow, 1, "R11 reg0 granted");
    unlock(); acc(1, 0, A_P1, 16'hB); check(wrAllow, 1, "R11 reg1 granted");
    unlock(); acc(1, 0, A_P2, 16'hC); check(wrAllow, 1, "R11 reg2 granted");
    idle(); check(errFlag, 0, "R11 no error after keyed writes");
    // R2 protection off
    lockCfg = 0;
    acc(1, 0, A_P0, 16'hD); check(wrAllow, 1, "R2 reg0 free");
    acc(1, 0, A_P1, 16'hE); check(wrAllow, 1, "R2 reg1 free");
    acc(1, 0, A_P2, 16'hF); check(wrDenied, 0, "R2 reg2 not denied");
    idle(); check(errFlag, 0, "R2 no error while unprotected");
    lockCfg = 1;
    acc(1, 0, A_P2, 16'h0); check(wrDenied, 1, "R8 protection back on");
    idle(); idle();
    finishRun();
  end

endmodule